// File: doc/BRIEF.md
# SECDED-Protected Local Data Memory

This block is a single-port, word-organised local data memory. Each 32-bit word is stored with seven check bits from an extended Hamming code, so one flipped bit in a word can be corrected and two flipped bits can be detected. The host issues requests over a valid/ready interface with a write enable, a word address, write data and four byte strobes. Each accepted request gets exactly one response, one cycle after the memory operation that finishes it.

A write with all four strobes set stores the data and its freshly computed check bits in one cycle. A byte or halfword write is split into two phases. The old word is read and corrected, the strobed bytes are merged into it, and the merged word is written back with new check bits. The request port is not ready during the second phase. Reads return corrected data and drive separate single-error and double-error pulses. A fault is raised for a double error only when both ECC and the exception enable are on. For testing, an injection mode stores a caller-supplied check-bit pattern in place of the generated one.

Top module: `secded_lmem`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high in the cycle after an accepted read or full write (strobes `1111`). A read of a clean word returns the stored data with no error flags.
- R2: The check bits follow a fixed code. Data bit i occupies the i-th code position in 3..38 that is not a power of two. Check bit k (k = 0..5) is the XOR of the data bits whose position has bit k set. Check bit 6 is the XOR of all data bits and check bits 0..5.
- R3: With `ecc_en` high, a word whose stored data plus check bits differ from a valid codeword in exactly one bit is read back as the original data. `err_single` is high and `fault` is low in the response cycle.
- R4: With `ecc_en` high, a word holding two bit errors raises `err_double` in the response cycle. The raw stored data is returned.
- R5: `fault` is high only when a double error is detected with both `ecc_en` and `exc_en` high. With `exc_en` low, a double error raises no fault.
- R6: With `ecc_en` low, reads return the raw stored data, and `err_single`, `err_double` and `fault` stay low.
- R7: A write with strobes other than `1111` is a sub-word write. `req_ready` is low for exactly the cycle after acceptance, and `rsp_valid` is high in that cycle. Afterwards the word holds the new bytes where a strobe is 1 and the old bytes (corrected when `ecc_en` is high) elsewhere. The word is stored with freshly generated check bits. Error flags in the response report the old word.
- R8: When the old word of a sub-word write holds a double error and `ecc_en` is high, the write is dropped and the stored word stays unchanged.
- R9: While `inj_en` is high at the edge where a word is written, `inj_code` is stored as its check bits instead of the generated code.
- R10: During and right after reset, `req_ready` is high and `rsp_valid`, `err_single`, `err_double` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte strobes, bit b covers data bits 8b+7..8b |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| ecc_en | input | 1 | Enables checking and correction |
| exc_en | input | 1 | Enables the double-error fault |
| inj_en | input | 1 | Store `inj_code` as check bits |
| inj_code | input | 7 | Check-bit pattern used for injection |
| err_single | output | 1 | Correctable error seen in this response |
| err_double | output | 1 | Uncorrectable error seen in this response |
| fault | output | 1 | Double-error fault |

## Verification
The assertions assume that the host holds `ecc_en`, `exc_en`, `inj_en` and `inj_code` steady from acceptance of a request until its response cycle has ended. They also assume that a word is written before it is read, since the storage itself is never reset. The stimulus changes the control inputs only between transactions, and it writes every address it reads. Injected codes are chosen to sit at most two bits away from a valid codeword, so each stored word is classified as clean, single-error or double-error without ambiguity.

// File: rtl/secded_pkg.sv
package secded_pkg;

   typedef enum logic [1:0] {
      PEND_NONE = 2'd0,
      PEND_RD   = 2'd1,
      PEND_WR   = 2'd2,
      PEND_RMW  = 2'd3
   } pend_t;

   // number of Hamming parity bits needed for dw data bits
   function automatic int par_bits(input int dw);
      int r;
      r = 0;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // code position of data bit idx: idx-th non-power-of-two position from 3
   function automatic int data_pos(input int idx);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int p = 3; p < 1024; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == idx && res == 0) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
   import secded_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]           data,
   output logic [par_bits(DATA_W)-1:0] par,
   output logic                        ovr
);
   localparam int P = par_bits(DATA_W);

   logic [DATA_W-1:0] colmask [P];

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam int POS = data_pos(i);
      for (genvar k = 0; k < P; k++) begin : g_col
         assign colmask[k][i] = ((POS >> k) % 2) == 1;
      end
   end

   for (genvar k = 0; k < P; k++) begin : g_par
      assign par[k] = ^(data & colmask[k]);
   end

   assign ovr = ^{data, par};

endmodule

// File: rtl/secded_dec.sv
module secded_dec
   import secded_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]           data,
   input  logic [par_bits(DATA_W)-1:0] spar,
   input  logic                        sovr,
   output logic [DATA_W-1:0]           corr,
   output logic                        single,
   output logic                        dbl
);
   localparam int P = par_bits(DATA_W);

   logic [P-1:0] rpar;
   logic         rovr;
   logic [P-1:0] syn;
   logic         ovr_err;

   secded_enc #(.DATA_W(DATA_W)) u_renc (
      .data (data),
      .par  (rpar),
      .ovr  (rovr)
   );

   assign syn     = spar ^ rpar;
   // parity over stored data and all stored check bits
   assign ovr_err = rovr ^ sovr ^ (^syn);
   assign single  = ovr_err;
   assign dbl     = !ovr_err && (syn != '0);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam logic [P-1:0] POS = P'(data_pos(i));
      assign corr[i] = data[i] ^ (single && (syn == POS));
   end

endmodule

// File: rtl/lmem_array.sv
module lmem_array #(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 39
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wd,
   output logic [WORD_W-1:0] rd
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wd;
      else if (re) rd <= mem[addr];
   end

endmodule

// File: rtl/secded_lmem.sv
module secded_lmem
   import secded_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_we,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic [DATA_W/8-1:0]         req_be,
   output logic                        rsp_valid,
   output logic [DATA_W-1:0]           rsp_rdata,
   input  logic                        ecc_en,
   input  logic                        exc_en,
   input  logic                        inj_en,
   input  logic [par_bits(DATA_W):0]   inj_code,
   output logic                        err_single,
   output logic                        err_double,
   output logic                        fault
);
   localparam int BE_W   = DATA_W / 8;
   localparam int P      = par_bits(DATA_W);
   localparam int CHK_W  = P + 1;
   localparam int WORD_W = DATA_W + CHK_W;

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W out of range 1..12");
   end

   pend_t               pend_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [BE_W-1:0]     be_q;

   logic                accept, full, pend_rmw, abort, checked;
   logic [WORD_W-1:0]   arr_rd, arr_wd;
   logic                arr_we, arr_re;
   logic [ADDR_W-1:0]   arr_addr;
   logic [DATA_W-1:0]   raw, corr, old_word, merged, wr_data;
   logic                dec_single, dec_dbl;
   logic [P-1:0]        gen_par;
   logic                gen_ovr;
   logic [CHK_W-1:0]    wr_chk;

   assign pend_rmw = (pend_q == PEND_RMW);
   assign req_ready = !pend_rmw;
   assign accept   = req_valid && req_ready;
   assign full     = &req_be;

   // ---- read path decode of the word returned by the array
   assign raw = arr_rd[DATA_W-1:0];

   secded_dec #(.DATA_W(DATA_W)) u_dec (
      .data   (raw),
      .spar   (arr_rd[DATA_W +: P]),
      .sovr   (arr_rd[WORD_W-1]),
      .corr   (corr),
      .single (dec_single),
      .dbl    (dec_dbl)
   );

   assign old_word = ecc_en ? corr : raw;
   assign abort    = ecc_en && dec_dbl;

   for (genvar b = 0; b < BE_W; b++) begin : g_merge
      assign merged[b*8 +: 8] = be_q[b] ? wdata_q[b*8 +: 8] : old_word[b*8 +: 8];
   end

   // ---- single encoder shared by full writes and merge write-back
   assign wr_data = pend_rmw ? merged : req_wdata;

   secded_enc #(.DATA_W(DATA_W)) u_enc (
      .data (wr_data),
      .par  (gen_par),
      .ovr  (gen_ovr)
   );

   assign wr_chk   = inj_en ? inj_code : {gen_ovr, gen_par};
   assign arr_wd   = {wr_chk, wr_data};
   assign arr_we   = pend_rmw ? !abort : (accept && req_we && full);
   assign arr_re   = !pend_rmw && accept && !(req_we && full);
   assign arr_addr = pend_rmw ? addr_q : req_addr;

   lmem_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
      .clk  (clk),
      .we   (arr_we),
      .re   (arr_re),
      .addr (arr_addr),
      .wd   (arr_wd),
      .rd   (arr_rd)
   );

   // ---- request tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= PEND_NONE;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else begin
         if (!accept)     pend_q <= PEND_NONE;
         else if (!req_we) pend_q <= PEND_RD;
         else if (full)   pend_q <= PEND_WR;
         else             pend_q <= PEND_RMW;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
      end
   end

   // ---- response
   assign checked    = (pend_q == PEND_RD) || pend_rmw;
   assign rsp_valid  = (pend_q != PEND_NONE);
   assign rsp_rdata  = (pend_q == PEND_RD) ? old_word : '0;
   assign err_single = checked && ecc_en && dec_single;
   assign err_double = checked && ecc_en && dec_dbl;
   assign fault      = err_double && exc_en;

   // ---- assertions
   // R1
   resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);
   // R7
   rmw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_we && !full) |=> !req_ready);
   // R7
   stall_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready);
   // R8
   abort_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_rmw && ecc_en && dec_dbl) |-> !arr_we);
   // R5
   fault_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (ecc_en && exc_en && err_double));
   // R6
   raw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !ecc_en) |-> !(err_single || err_double || fault));
   // R3
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(err_single && err_double));
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(err_single || err_double || fault));

endmodule

// File: tb/sim_secded_lmem.sv
`timescale 1ns/1ps
module sim_secded_lmem;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_we = 1'b0;
   logic        req_ready, rsp_valid, err_single, err_double, fault;
   logic [5:0]  req_addr = '0;
   logic [31:0] req_wdata = '0, rsp_rdata;
   logic [3:0]  req_be = '0;
   logic        ecc_en = 1'b1, exc_en = 1'b1, inj_en = 1'b0;
   logic [6:0]  inj_code = '0;

   int vectors = 0;
   int miscompares = 0;
   logic busy = 1'b0;
   logic busy_prev = 1'b0;

   // reference model state
   logic [31:0] m_raw  [64];
   logic [31:0] m_true [64];
   int          m_nerr [64];

   always #5 clk = ~clk;

   secded_lmem u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ecc_en(ecc_en), .exc_en(exc_en),
      .inj_en(inj_en), .inj_code(inj_code), .err_single(err_single),
      .err_double(err_double), .fault(fault)
   );

   function automatic logic [6:0] b_enc(input logic [31:0] d);
      logic [6:0] c;
      int idx;
      c = '0;
      idx = 0;
      for (int p = 1; p <= 38; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (d[idx]) c[5:0] = c[5:0] ^ p[5:0];
            idx++;
         end
      end
      c[6] = ^{d, c[5:0]};
      return c;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // idle comparison on every clock when no transaction is in flight (R10)
   always begin
      @(negedge clk);
      #1;
      if (rst_n && !busy && !busy_prev) begin
         chk("R10 idle ready", {31'b0, req_ready}, 32'd1);
         chk("R10 idle rsp/flags", {28'b0, rsp_valid, err_single, err_double, fault}, 32'd0);
      end
      busy_prev = busy;
   end

   // called at a negedge; returns at a negedge
   task automatic op(input logic we, input int a, input logic [31:0] wd, input logic [3:0] be,
                     input logic [31:0] exp_true, input int exp_nerr, input string tag);
      logic full, rmw, es, ed, ef;
      logic [31:0] oldc, nw;
      busy = 1'b1;
      full = we && (be == 4'hF);
      rmw  = we && !full;
      req_valid = 1'b1; req_we = we; req_addr = a[5:0]; req_wdata = wd; req_be = be;
      oldc = (ecc_en && m_nerr[a] == 1) ? m_true[a] : m_raw[a];
      es = !full && ecc_en && m_nerr[a] == 1;
      ed = !full && ecc_en && m_nerr[a] == 2;
      ef = ed && exc_en;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
      chk({tag, " ready"}, {31'b0, req_ready}, {31'b0, !rmw});
      chk({tag, " flags s/d/f"}, {29'b0, err_single, err_double, fault}, {29'b0, es, ed, ef});
      chk({tag, " rdata"}, rsp_rdata, we ? 32'h0 : oldc);
      if (rmw) begin
         @(negedge clk);
         chk({tag, " ready after merge"}, {31'b0, req_ready}, 32'd1);
         chk({tag, " rsp after merge"}, {31'b0, rsp_valid}, 32'd0);
      end
      if (we && !ed) begin
         for (int b = 0; b < 4; b++) nw[b*8 +: 8] = (full || be[b]) ? wd[b*8 +: 8] : oldc[b*8 +: 8];
         m_raw[a] = nw;
         if (inj_en) begin
            m_true[a] = exp_true;
            m_nerr[a] = exp_nerr;
         end else begin
            m_true[a] = nw;
            m_nerr[a] = 0;
         end
      end
      busy = 1'b0;
   endtask

   task automatic wr(input int a, input logic [31:0] d, input string tag);
      op(1'b1, a, d, 4'hF, d, 0, tag);
   endtask

   task automatic rd(input int a, input string tag);
      op(1'b0, a, 32'h0, 4'h0, 32'h0, 0, tag);
   endtask

   // store raw data with a chosen check pattern (R9)
   task automatic wr_inj(input int a, input logic [31:0] rawd, input logic [6:0] code,
                         input logic [31:0] truth, input int nerr, input string tag);
      inj_en = 1'b1; inj_code = code;
      op(1'b1, a, rawd, 4'hF, truth, nerr, tag);
      inj_en = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 64; i++) begin
         m_raw[i] = '0; m_true[i] = '0; m_nerr[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset ready", {31'b0, req_ready}, 32'd1);
      chk("R10 reset rsp/flags", {28'b0, rsp_valid, err_single, err_double, fault}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);

      // R1 full writes and back-to-back reads
      wr(0, 32'h0000_0000, "R1 wr0");
      wr(1, 32'hFFFF_FFFF, "R1 wr1");
      wr(2, 32'hA5A5_5A5A, "R1 wr2");
      wr(3, 32'h1234_5678, "R1 wr3");
      wr(63, 32'h8000_0001, "R1 wr63");
      rd(0, "R1 rd0"); rd(1, "R1 rd1"); rd(2, "R1 rd2"); rd(3, "R1 rd3"); rd(63, "R1 rd63");
      repeat (2) @(negedge clk);

      // R9/R2 injection of the exact generated code gives a clean word
      d = 32'h0F0F_3C3C;
      wr_inj(4, d, b_enc(d), d, 0, "R9 inj exact");
      rd(4, "R2 rd clean inj");

      // R3 single check-bit errors
      d = 32'hCAFE_F00D;
      for (int j = 0; j < 7; j++) begin
         wr_inj(10, d, b_enc(d) ^ 7'(1 << j), d, 1, "R9 inj chk flip");
         rd(10, "R3 rd chk flip");
      end
      // R3/R2 single data-bit errors
      for (int j = 0; j < 32; j += 5) begin
         wr_inj(11, d ^ (32'h1 << j), b_enc(d), d, 1, "R9 inj data flip");
         rd(11, "R3 rd data flip");
      end
      wr_inj(11, d ^ 32'h8000_0000, b_enc(d), d, 1, "R9 inj msb flip");
      rd(11, "R3 rd msb flip");

      // R4/R5 double errors
      exc_en = 1'b1;
      wr_inj(12, d ^ 32'h0000_0003, b_enc(d), d, 2, "R9 inj dbl data");
      rd(12, "R4 rd dbl fault");
      wr_inj(13, d, b_enc(d) ^ 7'h60, d, 2, "R9 inj dbl chk");
      rd(13, "R4 rd dbl chk");
      exc_en = 1'b0;
      rd(12, "R5 rd dbl nofault");
      exc_en = 1'b1;

      // R6 ECC disabled: raw data, no flags
      ecc_en = 1'b0;
      rd(11, "R6 rd single raw");
      rd(12, "R6 rd dbl raw");
      ecc_en = 1'b1;

      // R7 sub-word writes on clean word
      wr(20, 32'h1122_3344, "R7 wr base");
      op(1'b1, 20, 32'h0000_00AA, 4'b0001, 32'h0, 0, "R7 byte wr");
      op(1'b1, 20, 32'hBEEF_0000, 4'b1100, 32'h0, 0, "R7 half wr");
      rd(20, "R7 rd merged");
      op(1'b1, 20, 32'h0055_0000, 4'b0100, 32'h0, 0, "R7 byte2 wr");
      rd(20, "R7 rd merged2");
      // R7 sub-word write over a single-error word uses corrected data
      d = 32'h7777_8888;
      wr_inj(21, d ^ 32'h20, b_enc(d), d, 1, "R9 inj for rmw");
      op(1'b1, 21, 32'h0000_5500, 4'b0010, 32'h0, 0, "R7 rmw single");
      rd(21, "R7 rd rmw single");

      // R8 sub-word write over a double-error word is dropped
      op(1'b1, 12, 32'hDDDD_DDDD, 4'b0011, 32'h0, 0, "R8 rmw abort");
      rd(12, "R8 rd after abort");
      // with ECC off the merge proceeds on raw data
      ecc_en = 1'b0;
      op(1'b1, 13, 32'h0000_00EE, 4'b0001, 32'h0, 0, "R6 rmw ecc off");
      ecc_en = 1'b1;
      rd(13, "R7 rd after raw merge");

      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule